// File: doc/BRIEF.md
# SPI Word FIFO Data Path

This block sits between a 32-bit register bus and the word-level side of an SPI shifter. Software pushes transmit words into an output FIFO and pulls received words out of an input FIFO. The word length is programmable from 4 to 32 bits. Each word occupies 1, 2 or 4 bytes of the bus word. Transmit words are taken left-justified from the top of the written value. Received words are returned right-justified with the upper bits at zero.

Two pairs of transfer counters select when the done flags rise. One pair is active in FIFO mode and the other in block mode. In block mode, service flags also mark half-depth crossings. Every misuse of a FIFO sets an error bit: a push to a full output FIFO, a pop from an empty input FIFO, a shifter request on an empty output FIFO, and a shifter word arriving at a full input FIFO. Clock overrun and underrun reports from the shifter are kept in a second error register. All flags are cleared by writing ones, so writing back the value that was read clears exactly those bits. A level interrupt combines the enabled error bits with the service and done flags.

Register word addresses, in units of one 32-bit word:

| Address | Register |
|---|---|
| 0 | config |
| 1 | mode |
| 2 | FIFO-mode read count |
| 3 | FIFO-mode write count |
| 4 | block-mode input count |
| 5 | block-mode output count |
| 6 | status |
| 7 | error |
| 8 | error enable |
| 9 | clock error |
| 10 | clock error enable |
| 11 | transmit push |
| 12 | receive pop |
| 13 | FIFO depth, read only |

Top module: `spi_word_fifo`

## Requirements
- R1: Config bits [4:0] (address 0) hold N-1 for a word length N of 4..32 bits, and reset to 7. Words of at most 8 bits use 1 byte, at most 16 bits use 2 bytes, and longer words use 4 bytes.
- R2: A word written to address 11 reaches the shifter on `sh_tx_data` right-justified. Its bytes are taken from bits 31 downward, and it is masked to N bits.
- R3: A shifter word, once read from address 12, is right-justified and masked to N bits, with the upper bits zero.
- R4: Both FIFOs are first-in first-out with depth = B*2^(K+1), where B is 4 if BLK_CODE is 0 and 16*BLK_CODE otherwise. Address 13 reads the depth. Status (address 6) carries live bits: input full at bit 7, output full at bit 6, input not-empty at bit 5, output not-empty at bit 4.
- R5: A write to address 11 while the output FIFO is full drops the word and sets error bit 5 (address 7).
- R6: A read of address 12 while the input FIFO is empty returns zero and sets error bit 4.
- R7: A shifter request (`sh_tx_req`) on an empty output FIFO sets error bit 3 with `sh_tx_ok` low. A shifter word arriving at a full input FIFO is dropped and sets error bit 2.
- R8: With mode bit 0 clear, the counts at addresses 2 (input) and 3 (output) are active. With it set, the counts at addresses 4 (input) and 5 (output) are active. Status bit 11 (input done) sets when the received word total reaches a nonzero active input count. Status bit 10 (output done) does the same for words sent. Writing the mode register or any count register restarts both totals.
- R9: In block mode only, status bit 9 sets when a push brings the input level up to B words. Status bit 8 sets when a pop brings the output level down to B words from above.
- R10: Writing ones to status bits 11:8 or to error bits clears them, and writing zeros has no effect. A setting event in the same cycle wins over the clear. The live status bits 7:4 ignore writes.
- R11: A `sh_clk_over` pulse sets clock error bit 1 and a `sh_clk_under` pulse sets bit 0 (address 9). Both are cleared by writing ones.
- R12: `irq` is high while any error bit is set and enabled in its matching enable register (address 8 for bits 5:2, address 10 for bits 1:0), or while any of status bits 11:8 is set.
- R13: After reset both FIFOs are empty, all flags and counts are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the input FIFO at address 12) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| sh_tx_req | input | 1 | Shifter requests the next transmit word |
| sh_tx_data | output | 32 | Head transmit word, aligned and masked |
| sh_tx_ok | output | 1 | Output FIFO holds a word for the request |
| sh_rx_valid | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | 32 | Received word, right-justified |
| sh_clk_over | input | 1 | Shifter clock overrun report |
| sh_clk_under | input | 1 | Shifter clock underrun report |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check every cycle for the following:
- Overrun and underrun events raise their error bits one cycle later.
- A read of an empty input FIFO returns zero.
- The levels stay within the depth.
- A set and enabled error drives `irq`.

Some behaviour only the bench scenarios can show:
- Byte alignment across word lengths.
- FIFO ordering under mixed random traffic.
- Counter selection between the two modes.
- Service crossings in block mode only.
- Write-one-to-clear against the live status bits.

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int BLK_CODE = 0,
  parameter int FIFO_CODE = 0,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        sh_tx_req,
  output logic [31:0] sh_tx_data,
  output logic        sh_tx_ok,
  input  logic        sh_rx_valid,
  input  logic [31:0] sh_rx_data,
  input  logic        sh_clk_over,
  input  logic        sh_clk_under,
  output logic        irq
);
  localparam int BLK_WORDS = (BLK_CODE == 0) ? 4 : 16 * BLK_CODE;
  localparam int DEPTH = BLK_WORDS * (2 << FIFO_CODE);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] BLK_LVL = LW'(BLK_WORDS);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  localparam logic [3:0] A_CFG = 4'd0, A_MODE = 4'd1, A_RDCNT = 4'd2, A_WRCNT = 4'd3,
                         A_INCNT = 4'd4, A_OUTCNT = 4'd5, A_STAT = 4'd6, A_ERR = 4'd7,
                         A_ERREN = 4'd8, A_CLK = 4'd9, A_CLKEN = 4'd10, A_TX = 4'd11,
                         A_RX = 4'd12, A_GEOM = 4'd13;

  logic [4:0] len_m1;
  logic       blk_mode;
  logic [CNT_W-1:0] cnt_rd, cnt_wr, cnt_in, cnt_out, rx_prog, tx_prog;
  logic [5:2] err_q, err_en;
  logic [1:0] clk_q, clk_en;
  logic in_done, out_done, in_svc, out_svc;

  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_lvl, rx_lvl, tx_lvl_n, rx_lvl_n;

  wire wr = bus_wr;
  wire tx_full = (tx_lvl == FULL_LVL);
  wire rx_full = (rx_lvl == FULL_LVL);
  wire tx_empty = (tx_lvl == '0);
  wire rx_empty = (rx_lvl == '0);

  wire wr_tx = wr && bus_addr == A_TX;
  wire rd_rx = bus_rd && bus_addr == A_RX;
  wire tx_push = wr_tx && !tx_full;
  wire tx_pop = sh_tx_req && !tx_empty;
  wire rx_push = sh_rx_valid && !rx_full;
  wire rx_pop = rd_rx && !rx_empty;

  wire ev_out_ovr = wr_tx && tx_full;
  wire ev_in_und = rd_rx && rx_empty;
  wire ev_out_und = sh_tx_req && tx_empty;
  wire ev_in_ovr = sh_rx_valid && rx_full;

  wire restart = wr && (bus_addr == A_MODE || bus_addr == A_RDCNT || bus_addr == A_WRCNT ||
                        bus_addr == A_INCNT || bus_addr == A_OUTCNT);

  wire [CNT_W-1:0] in_target = blk_mode ? cnt_in : cnt_rd;
  wire [CNT_W-1:0] out_target = blk_mode ? cnt_out : cnt_wr;

  assign tx_lvl_n = tx_lvl + LW'(tx_push) - LW'(tx_pop);
  assign rx_lvl_n = rx_lvl + LW'(rx_push) - LW'(rx_pop);

  wire set_in_done = rx_push && in_target != '0 && (rx_prog + 1'b1) == in_target;
  wire set_out_done = tx_pop && out_target != '0 && (tx_prog + 1'b1) == out_target;
  wire set_in_svc = blk_mode && rx_lvl_n == BLK_LVL && rx_lvl < BLK_LVL;
  wire set_out_svc = blk_mode && tx_lvl_n == BLK_LVL && tx_lvl > BLK_LVL;

  wire [31:0] len_mask = 32'hFFFF_FFFF >> (5'd31 - len_m1);
  wire [4:0] tx_shift = (len_m1 <= 5'd7) ? 5'd24 : (len_m1 <= 5'd15) ? 5'd16 : 5'd0;

  assign sh_tx_ok = !tx_empty;
  assign sh_tx_data = tx_empty ? 32'd0 : ((tx_mem[tx_rp] >> tx_shift) & len_mask);

  wire st_wr = wr && bus_addr == A_STAT;
  wire er_wr = wr && bus_addr == A_ERR;
  wire ck_wr = wr && bus_addr == A_CLK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1 <= 5'd7;
      blk_mode <= 1'b0;
      cnt_rd <= '0; cnt_wr <= '0; cnt_in <= '0; cnt_out <= '0;
      err_en <= '0; clk_en <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_CFG:    len_m1 <= bus_wdata[4:0];
        A_MODE:   blk_mode <= bus_wdata[0];
        A_RDCNT:  cnt_rd <= bus_wdata[CNT_W-1:0];
        A_WRCNT:  cnt_wr <= bus_wdata[CNT_W-1:0];
        A_INCNT:  cnt_in <= bus_wdata[CNT_W-1:0];
        A_OUTCNT: cnt_out <= bus_wdata[CNT_W-1:0];
        A_ERREN:  err_en <= bus_wdata[5:2];
        A_CLKEN:  clk_en <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prog <= '0;
      tx_prog <= '0;
    end else if (restart) begin
      rx_prog <= '0;
      tx_prog <= '0;
    end else begin
      if (rx_push) rx_prog <= rx_prog + 1'b1;
      if (tx_pop) tx_prog <= tx_prog + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_done <= 1'b0; out_done <= 1'b0; in_svc <= 1'b0; out_svc <= 1'b0;
      err_q <= '0; clk_q <= '0;
    end else begin
      in_done  <= set_in_done  | (in_done  & ~(st_wr & bus_wdata[11]));
      out_done <= set_out_done | (out_done & ~(st_wr & bus_wdata[10]));
      in_svc   <= set_in_svc   | (in_svc   & ~(st_wr & bus_wdata[9]));
      out_svc  <= set_out_svc  | (out_svc  & ~(st_wr & bus_wdata[8]));
      err_q <= {ev_out_ovr, ev_in_und, ev_out_und, ev_in_ovr} |
               (err_q & ~({4{er_wr}} & bus_wdata[5:2]));
      clk_q <= {sh_clk_over, sh_clk_under} | (clk_q & ~({2{ck_wr}} & bus_wdata[1:0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST_PTR) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST_PTR) ? '0 : tx_rp + 1'b1;
      if (rx_push) rx_wp <= (rx_wp == LAST_PTR) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LAST_PTR) ? '0 : rx_rp + 1'b1;
      tx_lvl <= tx_lvl_n;
      rx_lvl <= rx_lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= sh_rx_data & len_mask;
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_rd) begin
      case (bus_addr)
        A_CFG:    bus_rdata = {27'd0, len_m1};
        A_MODE:   bus_rdata = {31'd0, blk_mode};
        A_RDCNT:  bus_rdata = 32'(cnt_rd);
        A_WRCNT:  bus_rdata = 32'(cnt_wr);
        A_INCNT:  bus_rdata = 32'(cnt_in);
        A_OUTCNT: bus_rdata = 32'(cnt_out);
        A_STAT:   bus_rdata = {20'd0, in_done, out_done, in_svc, out_svc,
                               rx_full, tx_full, !rx_empty, !tx_empty, 4'd0};
        A_ERR:    bus_rdata = {26'd0, err_q, 2'd0};
        A_ERREN:  bus_rdata = {26'd0, err_en, 2'd0};
        A_CLK:    bus_rdata = {30'd0, clk_q};
        A_CLKEN:  bus_rdata = {30'd0, clk_en};
        A_RX:     bus_rdata = rx_empty ? 32'd0 : rx_mem[rx_rp];
        A_GEOM:   bus_rdata = 32'(DEPTH);
        default:  bus_rdata = 32'd0;
      endcase
    end
  end

  assign irq = |(err_q & err_en) | |(clk_q & clk_en) | in_done | out_done | in_svc | out_svc;
endmodule

module spi_word_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [3:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          sh_tx_req,
  input logic          sh_tx_ok,
  input logic          sh_rx_valid,
  input logic          irq,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic [5:2]    err_q,
  input logic [5:2]    err_en
);
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));
  a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd11 && tx_lvl == LW'(DEPTH) && !sh_tx_req) |=> (err_q[5] && tx_lvl == LW'(DEPTH)));
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd12 && rx_lvl == '0) |-> (bus_rdata == 32'd0));
  a_r6_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd12 && rx_lvl == '0) |=> err_q[4]);
  a_r7_tx_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_tx_req && !sh_tx_ok) |=> err_q[3]);
  a_r7_rx_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rx_valid && rx_lvl == LW'(DEPTH) && !(bus_rd && bus_addr == 4'd12)) |=> (err_q[2] && rx_lvl == LW'(DEPTH)));
  a_r12_irq_enabled_error: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_q & err_en)) |-> irq);
endmodule

bind spi_word_fifo spi_word_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .sh_tx_req(sh_tx_req), .sh_tx_ok(sh_tx_ok),
  .sh_rx_valid(sh_rx_valid), .irq(irq), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .err_q(err_q), .err_en(err_en)
);

// File: tb/spi_word_fifo_bench.sv
module spi_word_fifo_bench;
  localparam int DEPTH = 8;
  localparam int BLK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sh_tx_req = 1'b0, sh_tx_ok;
  logic [31:0] sh_tx_data;
  logic sh_rx_valid = 1'b0;
  logic [31:0] sh_rx_data = '0;
  logic sh_clk_over = 1'b0, sh_clk_under = 1'b0;
  logic irq;

  int checks = 0, errors = 0;

  spi_word_fifo u_spi_word_fifo (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sh_tx_req(sh_tx_req),
    .sh_tx_data(sh_tx_data), .sh_tx_ok(sh_tx_ok), .sh_rx_valid(sh_rx_valid),
    .sh_rx_data(sh_rx_data), .sh_clk_over(sh_clk_over), .sh_clk_under(sh_clk_under),
    .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  function automatic logic [31:0] exp_tx(input logic [31:0] w, input int n);
    int nb;
    nb = (n <= 8) ? 1 : (n <= 16) ? 2 : 4;
    return (w >> (32 - 8 * nb)) & mask_of(n);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic take(output logic [31:0] d, output logic ok);
    @(negedge clk);
    sh_tx_req = 1'b1;
    #1 d = sh_tx_data; ok = sh_tx_ok;
    @(negedge clk);
    sh_tx_req = 1'b0;
  endtask

  task automatic give(input logic [31:0] d);
    @(negedge clk);
    sh_rx_valid = 1'b1; sh_rx_data = d;
    @(negedge clk);
    sh_rx_valid = 1'b0;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    logic ok;
    int n;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    #1 chk(irq == 1'b0, "R13 irq", {31'd0, irq}, 32'd0);
    rd(4'd6, v); chk(v == 0, "R13 status", v, 0);
    rd(4'd7, v); chk(v == 0, "R13 error", v, 0);
    rd(4'd9, v); chk(v == 0, "R13 clock error", v, 0);
    rd(4'd3, v); chk(v == 0, "R13 count", v, 0);
    rd(4'd0, v); chk(v == 32'd7, "R1 config reset", v, 7);
    rd(4'd13, v); chk(v == DEPTH, "R4 depth", v, DEPTH);

    // R1 R2 R3 alignment over random word lengths
    for (int i = 0; i < 40; i++) begin
      logic [31:0] w;
      n = 4 + int'($urandom_range(0, 28));
      if (i < 3) n = (i == 0) ? 8 : (i == 1) ? 16 : 32;
      wr(4'd0, 32'(n - 1));
      w = $urandom();
      wr(4'd11, w);
      take(v, ok);
      chk(ok && v == exp_tx(w, n), "R2 tx alignment", v, exp_tx(w, n));
      w = $urandom();
      give(w);
      rd(4'd12, v);
      chk(v == (w & mask_of(n)), "R3 rx alignment", v, w & mask_of(n));
    end
    wr(4'd0, 32'd31);

    // R4 R5 fill output FIFO, overrun drops
    for (int i = 0; i < DEPTH; i++) wr(4'd11, 32'hA000_0000 + i);
    rd(4'd6, v); chk(v[6] && v[4], "R4 out full/not-empty", v, 32'h50);
    wr(4'd11, 32'hDEAD_BEEF);
    rd(4'd7, v); chk(v[5], "R5 output overrun", v, 32'h20);
    for (int i = 0; i < DEPTH; i++) begin
      take(v, ok);
      chk(ok && v == 32'hA000_0000 + i, "R4 order and R5 drop", v, 32'hA000_0000 + i);
    end
    take(v, ok);
    chk(!ok, "R7 empty request", {31'd0, ok}, 0);
    rd(4'd7, v); chk(v[3], "R7 output underrun", v, 32'h08);

    // R6 empty read
    rd(4'd12, v); chk(v == 0, "R6 empty read zero", v, 0);
    rd(4'd7, v); chk(v[4], "R6 input underrun", v, 32'h10);

    // R7 input overrun
    for (int i = 0; i <= DEPTH; i++) give(32'h100 + i);
    rd(4'd6, v); chk(v[7] && v[5], "R4 in full/not-empty", v, 32'hA0);
    rd(4'd7, v); chk(v[2], "R7 input overrun", v, 32'h04);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'd12, v); chk(v == 32'h100 + i, "R7 rx drop order", v, 32'h100 + i);
    end

    // R10 write-one-to-clear
    rd(4'd7, v);
    wr(4'd7, 32'h20);
    rd(4'd7, e); chk(e == (v & ~32'h20), "R10 partial clear", e, v & ~32'h20);
    wr(4'd7, e);
    rd(4'd7, v); chk(v == 0, "R10 write-back clear", v, 0);
    wr(4'd11, 32'h1);
    wr(4'd6, 32'hFF0);
    rd(4'd6, v); chk(v[4] == 1'b1, "R10 live bit ignores write", v, 32'h10);
    take(v, ok);

    // R12 interrupt gating
    rd(4'd12, v);
    #1 chk(irq == 0, "R12 disabled error no irq", {31'd0, irq}, 0);
    wr(4'd8, 32'h10);
    #1 chk(irq == 1, "R12 enabled error irq", {31'd0, irq}, 1);
    wr(4'd7, 32'h3C);
    #1 chk(irq == 0, "R12 cleared", {31'd0, irq}, 0);

    // R11 clock errors
    @(negedge clk); sh_clk_under = 1'b1; @(negedge clk); sh_clk_under = 1'b0;
    @(negedge clk); sh_clk_over = 1'b1; @(negedge clk); sh_clk_over = 1'b0;
    rd(4'd9, v); chk(v == 32'h3, "R11 clock errors", v, 3);
    #1 chk(irq == 0, "R12 clock error masked", {31'd0, irq}, 0);
    wr(4'd10, 32'h1);
    #1 chk(irq == 1, "R12 clock error enabled", {31'd0, irq}, 1);
    wr(4'd9, 32'h3);
    rd(4'd9, v); chk(v == 0, "R11 clear", v, 0);
    #1 chk(irq == 0, "R12 after clear", {31'd0, irq}, 0);

    // R8 FIFO-mode counters
    wr(4'd1, 32'd0);
    wr(4'd5, 32'd7);
    wr(4'd3, 32'd3);
    for (int i = 0; i < 3; i++) wr(4'd11, 32'h5);
    take(v, ok); take(v, ok);
    rd(4'd6, v); chk(v[10] == 0, "R8 out done early", v, 0);
    take(v, ok);
    rd(4'd6, v); chk(v[10] == 1, "R8 out done fifo mode", v, 32'h400);
    #1 chk(irq == 1, "R12 done irq", {31'd0, irq}, 1);
    wr(4'd6, 32'hF00);
    // R8 block-mode counters, FIFO counter ignored
    wr(4'd1, 32'd1);
    wr(4'd3, 32'd1);
    wr(4'd5, 32'd2);
    wr(4'd11, 32'h7); wr(4'd11, 32'h8);
    take(v, ok);
    rd(4'd6, v); chk(v[10] == 0, "R8 fifo count ignored in block mode", v, 0);
    take(v, ok);
    rd(4'd6, v); chk(v[10] == 1, "R8 out done block mode", v, 32'h400);
    wr(4'd6, 32'hF00);
    wr(4'd1, 32'd0);
    wr(4'd2, 32'd2);
    give(32'h1);
    rd(4'd6, v); chk(v[11] == 0, "R8 in done early", v, 0);
    give(32'h2);
    rd(4'd6, v); chk(v[11] == 1, "R8 in done", v, 32'h800);
    rd(4'd12, v); rd(4'd12, v);
    wr(4'd2, 32'd0);
    wr(4'd6, 32'hF00);

    // R9 service flags
    wr(4'd1, 32'd1);
    for (int i = 0; i <= BLK; i++) wr(4'd11, 32'h9);
    rd(4'd6, v); chk(v[8] == 0, "R9 out svc before", v, 0);
    take(v, ok);
    rd(4'd6, v); chk(v[8] == 1, "R9 out svc block mode", v, 32'h100);
    wr(4'd6, 32'hF00);
    wr(4'd1, 32'd0);
    wr(4'd11, 32'h9);
    take(v, ok);
    rd(4'd6, v); chk(v[8] == 0, "R9 no out svc in fifo mode", v, 0);
    for (int i = 0; i < BLK; i++) take(v, ok);
    wr(4'd1, 32'd1);
    for (int i = 0; i < BLK; i++) give(32'h3);
    rd(4'd6, v); chk(v[9] == 1, "R9 in svc block mode", v, 32'h200);
    for (int i = 0; i < BLK; i++) rd(4'd12, v);
    wr(4'd1, 32'd0);
    wr(4'd6, 32'hF00);
    wr(4'd7, 32'h3C);

    // R4 random mixed traffic against a queue model
    n = 32;
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] w;
      k = int'($urandom_range(0, 4));
      w = $urandom();
      case (k)
        0: begin
          wr(4'd11, w);
          if (txq.size() < DEPTH) txq.push_back(w);
        end
        1: begin
          take(v, ok);
          if (txq.size() == 0) chk(!ok, "R7 random empty take", {31'd0, ok}, 0);
          else begin
            e = exp_tx(txq.pop_front(), n);
            chk(ok && v == e, "R4 random tx order", v, e);
          end
        end
        2: begin
          give(w);
          if (rxq.size() < DEPTH) rxq.push_back(w & mask_of(n));
        end
        3: begin
          rd(4'd12, v);
          e = (rxq.size() == 0) ? 32'd0 : rxq.pop_front();
          chk(v == e, "R4 random rx order", v, e);
        end
        default: begin
          n = 4 + int'($urandom_range(0, 28));
          wr(4'd0, 32'(n - 1));
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule